// File: doc/BRIEF.md
# Programmable One-Shot Pulse Generator

This block produces one pulse of programmable length. The pulse length is set by an 8-bit preload value and a 3-bit clock divider. When a start arrives, an up-counter loads the preload value and counts once per divided tick. The output stays active until the counter rolls over from its top value to zero. The start can come from a software bit in the control byte or from a falling edge on a hardware restart input. Software can end the pulse early, and so can a falling edge on a hardware stop input. Each hardware input has its own enable bit.

Two raw external sources, A and B, feed the hardware stop and restart inputs. A routing bit in the control byte swaps which source drives which input. A polarity bit chooses whether the active output level is high or low. The control byte can be read back. In the readback, bit 0 shows in real time whether the pulse is running.

Control byte layout, used for both writing and reading:
- bit 0: run / software trigger
- bit 1: restart enable
- bit 2: stop enable
- bits 5:3: prescale code
- bit 6: polarity
- bit 7: swap

Top module: `oneshot_pulse_gen`

## Requirements
- R1: After reset, the control readback is 0x00 and pulseOut is 0: the timer is idle, the output is active-high, both hardware triggers are off, the divider is 1 and the routing is unswapped.
- R2: A control write with bit 0 = 1 while the timer is idle starts the pulse. Readback bit 0 reads 1 from the next cycle.
- R3: With preload P and prescale code c in bits 5:3, the pulse lasts exactly (256 - P) * 2^c clock cycles. Codes 0 to 7 select divide-by 1, 2, 4, 8, 16, 32, 64 and 128, in that order.
- R4: When the counter overflows from 0xFF, the pulse ends and readback bit 0 clears by itself.
- R5: A control write with bit 0 = 0 ends a running pulse in the next cycle.
- R6: With stop enable (bit 2) set, a falling edge on the routed stop input ends the pulse at the third rising clock edge after the source falls.
- R7: With stop enable clear, edges on the stop input leave a running pulse untouched.
- R8: With restart enable (bit 1) set, a falling edge on the routed restart input starts an idle timer at the third rising clock edge after the source falls. With restart enable clear, such an edge has no effect.
- R9: A software start write or a hardware restart edge that arrives while the pulse is running does not reload or delay the counter. The total pulse length stays unchanged.
- R10: With polarity bit 6 = 0, pulseOut is 1 while the pulse is running. With bit 6 = 1, pulseOut is 0 while running and 1 while idle.
- R11: With swap bit 7 = 0, source B drives the stop input and source A drives the restart input. With bit 7 = 1, the two are exchanged.
- R12: If a stop request and a start request fall in the same cycle, the stop wins and the timer stays idle.
- R13: The divider restarts from zero on every start, so a pulse that starts after an earlier pulse was stopped part-way still has its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWe | input | 1 | Control byte write strobe |
| ctrlWdata | input | 8 | Control byte write data |
| preloadWe | input | 1 | Preload write strobe |
| preloadWdata | input | 8 | Counter preload value |
| srcA | input | 1 | Raw trigger source A (restart when unswapped) |
| srcB | input | 1 | Raw trigger source B (stop when unswapped) |
| pulseOut | output | 1 | Pulse output, polarity applied |
| ctrlRdata | output | 8 | Control byte readback with live run bit |

## Verification
The bench targets the following corner cases:
- Exact pulse length at the extreme preload values 0xFF and 0x00, and at the extreme divider codes. An off-by-one in the tick or overflow logic would stretch or shorten each pulse by one tick.
- Retriggers, both software and hardware, sent in the middle of a pulse. A design that reloads on them would give a pulse longer than 256 cycles.
- Falling edges on stop and restart in the same cycle. If start won, the timer would begin running.
- The swapped routing. A wrong mux would let source B stop the timer.
- A start right after a stop part-way through a pulse. A divider that is not cleared on start would give a pulse that is too short.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  // Strobes from the control side to the counting datapath
  typedef struct packed {
    logic load;   // reload counter and divider
    logic run;    // pulse in progress, count divided ticks
  } dp_strobe_t;
endpackage

// File: rtl/oneshot_fall_det.sv
module oneshot_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic prevQ;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= din;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else prevQ <= chain[STAGES-1];
  end

  assign fall = prevQ & ~chain[STAGES-1];
endmodule

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
  import oneshot_pkg::*;
#(
  parameter int PSC_W       = 3,
  parameter int SYNC_STAGES = 2,
  localparam int CTRL_W     = PSC_W + 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              srcA,
  input  logic              srcB,
  input  logic              wrap,
  output dp_strobe_t        strb,
  output logic              runFlag,
  output logic              stopHit,
  output logic [PSC_W-1:0]  pscCode,
  output logic              polarity,
  output logic [CTRL_W-1:0] ctrlRdata
);
  localparam int BIT_RS   = 1;
  localparam int BIT_SP   = 2;
  localparam int BIT_PSC  = 3;
  localparam int BIT_POL  = PSC_W + 3;
  localparam int BIT_SWAP = PSC_W + 4;

  logic rsEn, spEn, swapSel;
  logic stopRaw, restartRaw, stopFall, restartFall;
  logic swStart, swStop, hwStart, killRun, startGo;

  assign stopRaw    = swapSel ? srcA : srcB;
  assign restartRaw = swapSel ? srcB : srcA;

  oneshot_fall_det #(.STAGES(SYNC_STAGES)) u_stopDet (
    .clk(clk), .rstN(rstN), .din(stopRaw), .fall(stopFall));
  oneshot_fall_det #(.STAGES(SYNC_STAGES)) u_restartDet (
    .clk(clk), .rstN(rstN), .din(restartRaw), .fall(restartFall));

  assign swStart = ctrlWe & ctrlWdata[0];
  assign swStop  = ctrlWe & ~ctrlWdata[0];
  assign stopHit = spEn & stopFall;
  assign hwStart = rsEn & restartFall;
  assign killRun = swStop | stopHit | wrap;
  assign startGo = ~runFlag & (swStart | hwStart) & ~swStop & ~stopHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rsEn     <= 1'b0;
      spEn     <= 1'b0;
      pscCode  <= '0;
      polarity <= 1'b0;
      swapSel  <= 1'b0;
    end else if (ctrlWe) begin
      rsEn     <= ctrlWdata[BIT_RS];
      spEn     <= ctrlWdata[BIT_SP];
      pscCode  <= ctrlWdata[BIT_PSC +: PSC_W];
      polarity <= ctrlWdata[BIT_POL];
      swapSel  <= ctrlWdata[BIT_SWAP];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runFlag <= 1'b0;
    else if (killRun) runFlag <= 1'b0;
    else if (startGo) runFlag <= 1'b1;
  end

  assign strb.load = startGo;
  assign strb.run  = runFlag;
  assign ctrlRdata = {swapSel, polarity, pscCode, spEn, rsEn, runFlag};
endmodule

// File: rtl/oneshot_datapath.sv
module oneshot_datapath
  import oneshot_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PSC_W = 3,
  localparam int DIV_W = (1 << PSC_W) - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             preloadWe,
  input  logic [CNT_W-1:0] preloadWdata,
  input  logic [PSC_W-1:0] pscCode,
  input  dp_strobe_t       strb,
  output logic             wrap,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] preload;
  logic [DIV_W-1:0] pscCnt, divMask;
  logic tick;

  assign divMask = ~({DIV_W{1'b1}} << pscCode);
  assign tick    = strb.run & (pscCnt >= divMask);
  assign wrap    = tick & (count == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preload <= '0;
    else if (preloadWe) preload <= preloadWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      pscCnt <= '0;
    end else if (strb.load) begin
      count  <= preload;
      pscCnt <= '0;
    end else if (strb.run) begin
      if (tick) begin
        pscCnt <= '0;
        count  <= count + 1'b1;
      end else begin
        pscCnt <= pscCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/oneshot_pulse_gen.sv
module oneshot_pulse_gen
  import oneshot_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PSC_W       = 3,
  parameter int SYNC_STAGES = 2,
  localparam int CTRL_W     = PSC_W + 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              preloadWe,
  input  logic [CNT_W-1:0]  preloadWdata,
  input  logic              srcA,
  input  logic              srcB,
  output logic              pulseOut,
  output logic [CTRL_W-1:0] ctrlRdata
);
  dp_strobe_t       strb;
  logic             runFlag, stopHit, polarity, wrap;
  logic [PSC_W-1:0] pscCode;
  logic [CNT_W-1:0] count;

  oneshot_ctrl #(.PSC_W(PSC_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .srcA(srcA), .srcB(srcB), .wrap(wrap), .strb(strb),
    .runFlag(runFlag), .stopHit(stopHit), .pscCode(pscCode),
    .polarity(polarity), .ctrlRdata(ctrlRdata));

  oneshot_datapath #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_dp (
    .clk(clk), .rstN(rstN), .preloadWe(preloadWe),
    .preloadWdata(preloadWdata), .pscCode(pscCode), .strb(strb),
    .wrap(wrap), .count(count));

  assign pulseOut = runFlag ^ polarity;
endmodule

// File: rtl/oneshot_checker.sv
module oneshot_checker #(
  parameter int CNT_W  = 8,
  parameter int CTRL_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctrlWe,
  input logic [CTRL_W-1:0] ctrlWdata,
  input logic [CTRL_W-1:0] ctrlRdata,
  input logic              stopHit,
  input logic              wrap,
  input logic [CNT_W-1:0]  count
);
  AST_SW_START: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWe && ctrlWdata[0] && !ctrlRdata[0] && !stopHit |=> ctrlRdata[0]); // R2

  AST_SW_STOP: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWe && !ctrlWdata[0] |=> !ctrlRdata[0]); // R5

  AST_OVERFLOW_END: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> !ctrlRdata[0]); // R4

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    stopHit |=> !ctrlRdata[0]); // R12

  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdata[0] && !wrap |=>
      (count == $past(count)) || (count == CNT_W'($past(count) + 1'b1))); // R9
endmodule

bind oneshot_pulse_gen oneshot_checker #(.CNT_W(CNT_W), .CTRL_W(CTRL_W)) u_check (
  .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
  .ctrlRdata(ctrlRdata), .stopHit(stopHit), .wrap(wrap), .count(count));

// File: tb/test_oneshot_pulse_gen.sv
module test_oneshot_pulse_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic ctrlWe = 1'b0, preloadWe = 1'b0, srcA = 1'b1, srcB = 1'b1;
  logic [7:0] ctrlWdata = 8'h00, preloadWdata = 8'h00;
  logic pulseOut;
  logic [7:0] ctrlRdata;

  oneshot_pulse_gen i_oneshot_pulse_gen (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .preloadWe(preloadWe), .preloadWdata(preloadWdata),
    .srcA(srcA), .srcB(srcB), .pulseOut(pulseOut), .ctrlRdata(ctrlRdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  string phase = "R1";
  bit cmpOn = 1'b0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Behavioural reference model
  bit mRun, mRs, mSp, mPol, mSwap;
  int mPsc, mCnt, mPre, mSince;
  bit sHist [3];
  bit rHist [3];
  bit sFall, rFall, swSt, swSp, hwSt, hwSp, tickM, wrapM;

  always @(posedge clk) begin
    if (!rstN) begin
      mRun = 0; mRs = 0; mSp = 0; mPol = 0; mSwap = 0;
      mPsc = 0; mCnt = 0; mPre = 0; mSince = 0;
      foreach (sHist[i]) begin sHist[i] = 0; rHist[i] = 0; end
    end else begin
      sFall = sHist[2] && !sHist[1];
      rFall = rHist[2] && !rHist[1];
      sHist[2] = sHist[1]; sHist[1] = sHist[0]; sHist[0] = mSwap ? srcA : srcB;
      rHist[2] = rHist[1]; rHist[1] = rHist[0]; rHist[0] = mSwap ? srcB : srcA;
      swSt = ctrlWe && ctrlWdata[0];
      swSp = ctrlWe && !ctrlWdata[0];
      hwSp = mSp && sFall;
      hwSt = mRs && rFall;
      tickM = 0;
      if (mRun) begin
        mSince++;
        tickM = (mSince % (1 << mPsc)) == 0;
      end
      wrapM = tickM && (mCnt == 255);
      if (swSp || hwSp || wrapM) mRun = 0;
      else if (!mRun && (swSt || hwSt)) begin mRun = 1; mCnt = mPre; mSince = 0; end
      else if (mRun && tickM) mCnt = mCnt + 1;
      if (ctrlWe) begin
        mRs = ctrlWdata[1]; mSp = ctrlWdata[2]; mPsc = int'(ctrlWdata[5:3]);
        mPol = ctrlWdata[6]; mSwap = ctrlWdata[7];
      end
      if (preloadWe) mPre = int'(preloadWdata);
    end
  end

  always @(negedge clk) begin
    if (cmpOn) begin
      check({phase, " pulseOut vs model"}, int'(pulseOut), int'(mRun ^ mPol));
      check({phase, " readback vs model"}, int'(ctrlRdata),
            int'({mSwap, mPol, mPsc[2:0], mSp, mRs, mRun}));
    end
  end

  function automatic logic [7:0] mk(bit run, bit rs, bit sp, int psc, bit pol, bit sw);
    return {sw, pol, psc[2:0], sp, rs, run};
  endfunction

  task automatic wrCtrl(logic [7:0] v);
    ctrlWdata = v; ctrlWe = 1'b1;
    @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  task automatic wrPre(logic [7:0] v);
    preloadWdata = v; preloadWe = 1'b1;
    @(negedge clk);
    preloadWe = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(int expLen, string tag);
    int n = 0;
    while (ctrlRdata[0] && n < 70000) begin
      n++;
      @(negedge clk);
    end
    check(tag, n, expLen);
  endtask

  task automatic widthCase(int p, int code);
    phase = "R3";
    wrPre(p[7:0]);
    wrCtrl(mk(1, 0, 0, code, 0, 0));
    check("R2 run bit after software start", int'(ctrlRdata[0]), 1);
    measure((256 - p) << code, "R3 pulse width");
    check("R4 run bit self-clears", int'(ctrlRdata[0]), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual still running expected finished");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    cmpOn = 1'b1;
    check("R1 reset readback", int'(ctrlRdata), 0);
    check("R1 reset pulseOut", int'(pulseOut), 0);

    widthCase(250, 0);
    widthCase(8'hF0, 2);
    widthCase(8'hFE, 7);
    widthCase(8'hFF, 1);
    widthCase(0, 0);
    widthCase(8'hFC, 5);

    phase = "R5";
    wrPre(0);
    wrCtrl(mk(1, 0, 0, 3, 0, 0));
    idle(10);
    wrCtrl(mk(0, 0, 0, 3, 0, 0));
    check("R5 software stop run bit", int'(ctrlRdata[0]), 0);
    check("R5 software stop pulseOut", int'(pulseOut), 0);

    phase = "R13";
    wrPre(8'hFE);
    wrCtrl(mk(1, 0, 0, 3, 0, 0));
    idle(5);
    wrCtrl(mk(0, 0, 0, 3, 0, 0));
    wrCtrl(mk(1, 0, 0, 3, 0, 0));
    measure(16, "R13 full width after partial run");

    phase = "R10";
    wrCtrl(mk(0, 0, 0, 0, 1, 0));
    check("R10 idle level inverted", int'(pulseOut), 1);
    wrPre(8'hF8);
    wrCtrl(mk(1, 0, 0, 0, 1, 0));
    check("R10 active level inverted", int'(pulseOut), 0);
    measure(8, "R10 width under inverted polarity");
    check("R10 back to idle level", int'(pulseOut), 1);
    wrCtrl(mk(0, 0, 0, 0, 0, 0));

    phase = "R6";
    wrPre(0);
    wrCtrl(mk(1, 0, 1, 2, 0, 0));
    idle(4);
    srcB = 1'b0;
    idle(2);
    check("R6 still running before third edge", int'(ctrlRdata[0]), 1);
    idle(1);
    check("R6 hardware stop applied", int'(ctrlRdata[0]), 0);
    srcB = 1'b1;
    idle(4);

    phase = "R7";
    wrCtrl(mk(1, 0, 0, 2, 0, 0));
    srcB = 1'b0;
    idle(6);
    check("R7 stop edge ignored when disabled", int'(ctrlRdata[0]), 1);
    srcB = 1'b1;
    idle(3);
    wrCtrl(mk(0, 0, 0, 0, 0, 0));

    phase = "R8";
    wrCtrl(mk(0, 1, 0, 0, 0, 0));
    wrPre(8'hF0);
    srcA = 1'b0;
    idle(2);
    check("R8 idle before third edge", int'(ctrlRdata[0]), 0);
    idle(1);
    check("R8 hardware restart applied", int'(ctrlRdata[0]), 1);
    srcA = 1'b1;
    measure(16, "R8 width after hardware restart");
    wrCtrl(mk(0, 0, 0, 0, 0, 0));
    srcA = 1'b0;
    idle(6);
    check("R8 restart edge ignored when disabled", int'(ctrlRdata[0]), 0);
    srcA = 1'b1;
    idle(3);

    phase = "R9";
    wrPre(0);
    wrCtrl(mk(0, 1, 0, 0, 0, 0));
    wrCtrl(mk(1, 1, 0, 0, 0, 0));
    begin
      int n = 0;
      while (ctrlRdata[0] && n < 1000) begin
        n++;
        ctrlWe = 1'b0;
        if (n == 40) begin ctrlWdata = mk(1, 1, 0, 0, 0, 0); ctrlWe = 1'b1; end
        if (n == 80) srcA = 1'b0;
        if (n == 90) srcA = 1'b1;
        @(negedge clk);
      end
      ctrlWe = 1'b0;
      check("R9 retriggers leave width unchanged", n, 256);
    end
    idle(3);

    phase = "R11";
    wrCtrl(mk(1, 0, 1, 0, 0, 1));
    srcB = 1'b0;
    idle(5);
    check("R11 source B not a stop when swapped", int'(ctrlRdata[0]), 1);
    srcA = 1'b0;
    idle(2);
    check("R11 running before routed stop lands", int'(ctrlRdata[0]), 1);
    idle(1);
    check("R11 source A stops when swapped", int'(ctrlRdata[0]), 0);
    srcA = 1'b1; srcB = 1'b1;
    idle(4);
    wrCtrl(mk(0, 0, 0, 0, 0, 0));
    idle(4);

    phase = "R12";
    wrCtrl(mk(0, 1, 1, 0, 0, 0));
    srcA = 1'b0; srcB = 1'b0;
    idle(6);
    check("R12 stop beats simultaneous restart", int'(ctrlRdata[0]), 0);
    srcA = 1'b1; srcB = 1'b1;
    idle(4);

    cmpOn = 1'b0;
    summary();
    $finish;
  end
endmodule